// File: doc/BRIEF.md
# Timed SPI Master Controller

This block is a serial peripheral interface master that moves 8-bit frames between a host and one external device. The host pushes bytes into a 4-entry transmit queue through a write strobe and pops received bytes from a 4-entry receive queue through a read strobe. If the controller is idle, the first byte pushed starts a transfer. More bytes can be pushed while that transfer runs. The controller raises and releases its single active-low chip select on its own. It keeps chip select low across back-to-back frames for as long as the transmit queue still holds data.

All sequencing advances on a functional clock enable (`tickEn`) that is qualified with the system clock. Six configuration inputs set the timing. Each one is a delay count measured in ticks:
- the lead time from chip select falling to the first clock half-period;
- the low and high halves of SCK;
- the gap between consecutive frames;
- the trail time from the last SCK edge to chip select rising;
- the minimum rest time with chip select high.

The link runs in mode 0. SCK idles low, data goes out most significant bit first, the device input is sampled on the rising edge, and the output is advanced on the falling edge. Nothing happens while the enable input is low.

Top module: `spi_timed_master`

## Requirements
- R1: After reset, csN is 1, sck is 0, txFull is 0, rxEmpty is 1, busy is 0 and rxOverflow is 0.
- R2: While enable is 0, the controller is held idle with csN=1 and sck=0. Host writes and reads are ignored, and rxOverflow is cleared. Queue contents are kept.
- R3: The transmit queue holds 4 bytes. txFull is 1 exactly when it holds 4. A write while txFull is 1 is dropped.
- R4: When the controller is idle and the transmit queue is non-empty on a tick, the controller pops a byte and drives csN to 0. csN then stays low for csToClk+1 ticks before the first SCK low half begins.
- R5: Each frame is 8 bits, most significant bit first, in mode 0. SCK is 0 whenever csN is 1. sdo changes only while SCK is low. sdi is sampled at each rising SCK edge into a byte, first sample in bit 7.
- R6: Each SCK low half lasts sckLow+1 ticks and each high half lasts sckHigh+1 ticks.
- R7: If the transmit queue is non-empty at the tick that ends a frame's last high half, csN stays 0. SCK then stays low for frameGap+1 ticks, the next byte is popped, and its first low half starts.
- R8: Otherwise csN stays 0 for clkToCs+1 ticks after the last high half ends. It then stays 1 for csRest+4 ticks before a new transfer may assert it.
- R9: The byte sampled during a frame is pushed into a 4-entry receive queue on the tick that ends the frame. rxData shows the oldest entry, rxEmpty is 1 when the queue holds none, and rxRead pops one entry.
- R10: A frame that completes while the receive queue holds 4 bytes is discarded. It sets rxOverflow, which stays 1 until enable goes to 0.
- R11: busy is 1 whenever the controller is not idle or the transmit queue holds data.
- R12: Clock cycles with tickEn at 0 advance no delay count, SCK phase or frame state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable |
| tickEn | input | 1 | Functional clock enable that paces all timing |
| csToClk | input | 8 | Lead delay, value+1 ticks |
| clkToCs | input | 8 | Trail delay, value+1 ticks |
| frameGap | input | 8 | Gap between frames, value+1 ticks |
| csRest | input | 8 | Minimum chip-select-high time, value+4 ticks |
| sckLow | input | 8 | SCK low half-period, value+1 ticks |
| sckHigh | input | 8 | SCK high half-period, value+1 ticks |
| txWrite | input | 1 | Push txData into the transmit queue |
| txData | input | 8 | Byte to transmit |
| rxRead | input | 1 | Pop the oldest received byte |
| rxData | output | 8 | Oldest received byte |
| txFull | output | 1 | Transmit queue holds 4 bytes |
| rxEmpty | output | 1 | Receive queue is empty |
| busy | output | 1 | Transfer in progress or transmit data pending |
| rxOverflow | output | 1 | Sticky flag for a discarded received byte |
| sck | output | 1 | Serial clock |
| csN | output | 1 | Active-low chip select |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The bench builds the block with its default parameters: 8-bit frames, 4-entry queues and 8-bit delay fields. With queues that shallow, a run of only a few bytes reaches a full transmit queue, a dropped host write and a receive overflow. The delay fields are driven at run time with small values, including all zeros, so the shortest lead, gap, trail and half-period paths are each covered. One pass runs with a tick on only every third clock, which checks that idle cycles hold every count.

// File: rtl/spi_tm_pkg.sv
package spi_tm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_LOW,
    PH_HIGH,
    PH_GAP,
    PH_TRAIL,
    PH_REST
  } phase_e;

  // Strobes from the sequencer to the datapath, each valid for one clock
  typedef struct packed {
    logic loadTx;    // pop transmit queue head into the output shifter
    logic sampleIn;  // capture sdi at a rising SCK edge
    logic shiftOut;  // advance the output shifter at a falling SCK edge
    logic pushRx;    // frame complete, store the captured byte
  } strobe_t;

endpackage

// File: rtl/spi_tm_fifo.sv
module spi_tm_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdData = mem[rdPtr];
  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);

endmodule

// File: rtl/spi_tm_ctrl.sv
module spi_tm_ctrl
  import spi_tm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DLY_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             tickEn,
  input  logic             txEmpty,
  input  logic [DLY_W-1:0] csToClk,
  input  logic [DLY_W-1:0] clkToCs,
  input  logic [DLY_W-1:0] frameGap,
  input  logic [DLY_W-1:0] csRest,
  input  logic [DLY_W-1:0] sckLow,
  input  logic [DLY_W-1:0] sckHigh,
  output strobe_t          strb,
  output logic             active,
  output logic             sck,
  output logic             csN
);
  localparam int CNT_W = DLY_W + 2;
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] REST_EXTRA = CNT_W'(3);

  phase_e           phase;
  logic [CNT_W-1:0] remain;
  logic [BIT_W-1:0] bitIdx;
  logic             step, expire, lastBit;

  assign step    = enable && tickEn;
  assign expire  = step && (remain == '0);
  assign lastBit = (bitIdx == LAST_BIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      remain <= '0;
      bitIdx <= '0;
    end else if (!enable) begin
      phase  <= PH_IDLE;
      remain <= '0;
      bitIdx <= '0;
    end else if (tickEn) begin
      if (phase != PH_IDLE && remain != '0) begin
        remain <= remain - 1'b1;
      end else begin
        case (phase)
          PH_IDLE: if (!txEmpty) begin
            phase  <= PH_LEAD;
            remain <= CNT_W'(csToClk);
            bitIdx <= '0;
          end
          PH_LEAD: begin
            phase  <= PH_LOW;
            remain <= CNT_W'(sckLow);
          end
          PH_LOW: begin
            phase  <= PH_HIGH;
            remain <= CNT_W'(sckHigh);
          end
          PH_HIGH: begin
            if (lastBit) begin
              bitIdx <= '0;
              if (!txEmpty) begin
                phase  <= PH_GAP;
                remain <= CNT_W'(frameGap);
              end else begin
                phase  <= PH_TRAIL;
                remain <= CNT_W'(clkToCs);
              end
            end else begin
              bitIdx <= bitIdx + 1'b1;
              phase  <= PH_LOW;
              remain <= CNT_W'(sckLow);
            end
          end
          PH_GAP: begin
            phase  <= PH_LOW;
            remain <= CNT_W'(sckLow);
          end
          PH_TRAIL: begin
            phase  <= PH_REST;
            remain <= CNT_W'(csRest) + REST_EXTRA;
          end
          PH_REST: phase <= PH_IDLE;
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.loadTx   = step && ((phase == PH_IDLE && !txEmpty) ||
                             (phase == PH_GAP && remain == '0));
    strb.sampleIn = expire && (phase == PH_LOW);
    strb.shiftOut = expire && (phase == PH_HIGH) && !lastBit;
    strb.pushRx   = expire && (phase == PH_HIGH) && lastBit;
  end

  assign active = (phase != PH_IDLE);
  assign sck    = (phase == PH_HIGH);
  assign csN    = (phase == PH_IDLE) || (phase == PH_REST);

endmodule

// File: rtl/spi_tm_datapath.sv
module spi_tm_datapath
  import spi_tm_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  strobe_t           strb,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxRead,
  input  logic              sdi,
  output logic [DATA_W-1:0] rxData,
  output logic              txFull,
  output logic              txEmpty,
  output logic              rxEmpty,
  output logic              rxOverflow,
  output logic              sdo
);
  logic [DATA_W-1:0] txHead, outShift, inShift;
  logic              rxFull, txPush, rxPop, rxPush;

  assign txPush = enable && txWrite && !txFull;
  assign rxPop  = enable && rxRead && !rxEmpty;
  assign rxPush = strb.pushRx && !rxFull;

  spi_tm_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rstN(rstN),
    .push(txPush), .pop(strb.loadTx),
    .wrData(txData), .rdData(txHead),
    .full(txFull), .empty(txEmpty)
  );

  spi_tm_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rstN(rstN),
    .push(rxPush), .pop(rxPop),
    .wrData(inShift), .rdData(rxData),
    .full(rxFull), .empty(rxEmpty)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outShift   <= '0;
      inShift    <= '0;
      rxOverflow <= 1'b0;
    end else begin
      if (strb.loadTx)        outShift <= txHead;
      else if (strb.shiftOut) outShift <= {outShift[DATA_W-2:0], 1'b0};
      if (strb.sampleIn)      inShift  <= {inShift[DATA_W-2:0], sdi};
      if (!enable)                         rxOverflow <= 1'b0;
      else if (strb.pushRx && rxFull)      rxOverflow <= 1'b1;
    end
  end

  assign sdo = outShift[DATA_W-1];

endmodule

// File: rtl/spi_timed_master.sv
module spi_timed_master
  import spi_tm_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int DLY_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              tickEn,
  input  logic [DLY_W-1:0]  csToClk,
  input  logic [DLY_W-1:0]  clkToCs,
  input  logic [DLY_W-1:0]  frameGap,
  input  logic [DLY_W-1:0]  csRest,
  input  logic [DLY_W-1:0]  sckLow,
  input  logic [DLY_W-1:0]  sckHigh,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxRead,
  output logic [DATA_W-1:0] rxData,
  output logic              txFull,
  output logic              rxEmpty,
  output logic              busy,
  output logic              rxOverflow,
  output logic              sck,
  output logic              csN,
  output logic              sdo,
  input  logic              sdi
);
  strobe_t strb;
  logic    txEmpty, active;

  spi_tm_ctrl #(.DATA_W(DATA_W), .DLY_W(DLY_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .tickEn(tickEn),
    .txEmpty(txEmpty),
    .csToClk(csToClk), .clkToCs(clkToCs), .frameGap(frameGap),
    .csRest(csRest), .sckLow(sckLow), .sckHigh(sckHigh),
    .strb(strb), .active(active), .sck(sck), .csN(csN)
  );

  spi_tm_datapath #(.DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .enable(enable), .strb(strb),
    .txWrite(txWrite), .txData(txData), .rxRead(rxRead), .sdi(sdi),
    .rxData(rxData), .txFull(txFull), .txEmpty(txEmpty),
    .rxEmpty(rxEmpty), .rxOverflow(rxOverflow), .sdo(sdo)
  );

  assign busy = active || !txEmpty;

endmodule

// File: rtl/spi_tm_checker.sv
module spi_tm_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic tickEn,
  input logic txWrite,
  input logic txFull,
  input logic rxOverflow,
  input logic sck,
  input logic csN,
  input logic sdo
);
  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (csN && !sck));

  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !tickEn && txFull && txWrite) |=> txFull);

  // R5
  idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);

  // R5
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> $stable(sdo));

  // R10
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxOverflow && enable) |=> rxOverflow);

  // R12
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !tickEn) |=> ($stable(csN) && $stable(sck)));

endmodule

bind spi_timed_master spi_tm_checker u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .tickEn(tickEn),
  .txWrite(txWrite), .txFull(txFull), .rxOverflow(rxOverflow),
  .sck(sck), .csN(csN), .sdo(sdo)
);

// File: tb/test_spi_timed_master.sv
module test_spi_timed_master;
  localparam int CLK_PERIOD = 10;
  localparam int QD = 4;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic tickEn = 1'b0;
  logic [7:0] csToClk = '0, clkToCs = '0, frameGap = '0, csRest = '0;
  logic [7:0] sckLow = '0, sckHigh = '0;
  logic txWrite = 1'b0;
  logic [7:0] txData = '0;
  logic rxRead = 1'b0;
  logic sdi = 1'b0;
  logic [7:0] rxData;
  logic txFull, rxEmpty, busy, rxOverflow, sck, csN, sdo;

  spi_timed_master i_spi_timed_master (
    .clk(clk), .rstN(rstN), .enable(enable), .tickEn(tickEn),
    .csToClk(csToClk), .clkToCs(clkToCs), .frameGap(frameGap),
    .csRest(csRest), .sckLow(sckLow), .sckHigh(sckHigh),
    .txWrite(txWrite), .txData(txData), .rxRead(rxRead),
    .rxData(rxData), .txFull(txFull), .rxEmpty(rxEmpty), .busy(busy),
    .rxOverflow(rxOverflow), .sck(sck), .csN(csN), .sdo(sdo), .sdi(sdi)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int tickDiv = 1;
  int tickCnt = 0;
  string extraTag = "";

  // Behavioural reference: 0 idle, 1 lead, 2 low, 3 high, 4 gap, 5 trail, 6 rest
  int ph = 0, rem = 0, bits = 0;
  logic [7:0] outB = '0, inB = '0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  bit ovf = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // tick and serial input stimulus, changed a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    tickCnt++;
    tickEn = (tickDiv == 0) ? 1'b0 : ((tickCnt % tickDiv) == 0);
    sdi = 1'($urandom_range(0, 1));
  end

  always @(posedge clk or negedge rstN) begin
    int txPre, rxPre;
    bit cPop, cPush;
    logic [7:0] cByte;
    if (!rstN) begin
      ph = 0; rem = 0; bits = 0; ovf = 0;
      txq.delete(); rxq.delete();
    end else if (!enable) begin
      ph = 0; rem = 0; bits = 0; ovf = 0;
    end else begin
      txPre = txq.size();
      rxPre = rxq.size();
      cPop = 0; cPush = 0; cByte = '0;
      if (tickEn) begin
        if (ph != 0 && rem > 0) rem--;
        else begin
          case (ph)
            0: if (txPre > 0) begin
                 outB = txq[0]; cPop = 1; ph = 1; rem = csToClk; bits = 0;
               end
            1: begin ph = 2; rem = sckLow; end
            2: begin inB = {inB[6:0], sdi}; ph = 3; rem = sckHigh; end
            3: if (bits == 7) begin
                 cPush = 1; cByte = inB; bits = 0;
                 if (txPre > 0) begin ph = 4; rem = frameGap; end
                 else begin ph = 5; rem = clkToCs; end
               end else begin
                 outB = outB << 1; bits++; ph = 2; rem = sckLow;
               end
            4: begin outB = txq[0]; cPop = 1; ph = 2; rem = sckLow; end
            5: begin ph = 6; rem = csRest + 3; end
            default: ph = 0;
          endcase
        end
      end
      if (rxRead && rxPre > 0) void'(rxq.pop_front());
      if (cPush) begin
        if (rxPre == QD) ovf = 1;
        else rxq.push_back(cByte);
      end
      if (cPop) void'(txq.pop_front());
      if (txWrite && txPre < QD) txq.push_back(txData);
    end
  end

  // compare against the reference on every clock, away from the active edge
  always @(negedge clk) begin
    logic expCs;
    if (rstN) begin
      expCs = !(ph >= 1 && ph <= 5);
      chk({"R4 R7 R8 csN", extraTag}, 32'(csN), 32'(expCs));
      chk({"R5 R6 sck", extraTag}, 32'(sck), 32'(ph == 3));
      if (!expCs) chk({"R5 sdo", extraTag}, 32'(sdo), 32'(outB[7]));
      chk({"R3 txFull", extraTag}, 32'(txFull), 32'(txq.size() == QD));
      chk({"R9 rxEmpty", extraTag}, 32'(rxEmpty), 32'(rxq.size() == 0));
      if (rxq.size() > 0) chk({"R9 rxData", extraTag}, 32'(rxData), 32'(rxq[0]));
      chk({"R10 rxOverflow", extraTag}, 32'(rxOverflow), 32'(ovf));
      chk({"R11 busy", extraTag}, 32'(busy), 32'(ph != 0 || txq.size() > 0));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic pushByte(logic [7:0] b);
    @(posedge clk); #(CLK_PERIOD/4);
    txWrite = 1'b1; txData = b;
    @(posedge clk); #(CLK_PERIOD/4);
    txWrite = 1'b0;
  endtask

  task automatic popByte();
    @(posedge clk); #(CLK_PERIOD/4);
    rxRead = 1'b1;
    @(posedge clk); #(CLK_PERIOD/4);
    rxRead = 1'b0;
  endtask

  task automatic waitIdle();
    do @(posedge clk); while (busy);
    repeat (2) @(posedge clk);
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    waitCycles(3);
    @(negedge clk);
    // R1 reset state
    chk("R1 csN", 32'(csN), 32'd1);
    chk("R1 sck", 32'(sck), 32'd0);
    chk("R1 txFull", 32'(txFull), 32'd0);
    chk("R1 rxEmpty", 32'(rxEmpty), 32'd1);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 rxOverflow", 32'(rxOverflow), 32'd0);
    @(posedge clk); #(CLK_PERIOD/4);
    rstN = 1'b1;

    // R2: disabled block ignores the host
    extraTag = " R2";
    pushByte(8'h3C);
    pushByte(8'hC3);
    popByte();
    waitCycles(5);
    @(negedge clk);
    chk("R2 busy", 32'(busy), 32'd0);
    chk("R2 csN", 32'(csN), 32'd1);
    chk("R2 rxEmpty", 32'(rxEmpty), 32'd1);
    extraTag = "";

    // single frame with distinct delays
    csToClk = 8'd2; clkToCs = 8'd1; frameGap = 8'd0; csRest = 8'd1;
    sckLow = 8'd1; sckHigh = 8'd0;
    @(posedge clk); #(CLK_PERIOD/4);
    enable = 1'b1;
    pushByte(8'hA5);
    waitIdle();

    // fill the transmit queue with ticks stopped, then a dropped write (R3)
    tickDiv = 0;
    csToClk = 8'd0; clkToCs = 8'd3; frameGap = 8'd2; csRest = 8'd2;
    sckLow = 8'd0; sckHigh = 8'd1;
    pushByte(8'h10); pushByte(8'h81); pushByte(8'h42); pushByte(8'h0F);
    pushByte(8'hEE);
    @(negedge clk);
    chk("R3 full after four", 32'(txFull), 32'd1);
    tickDiv = 1;
    waitCycles(30);
    pushByte(8'h5A);
    pushByte(8'hF0);
    waitIdle();
    @(negedge clk);
    chk("R10 overflow set", 32'(rxOverflow), 32'd1);
    for (int i = 0; i < 4; i++) popByte();
    @(negedge clk);
    chk("R9 drained", 32'(rxEmpty), 32'd1);

    // zero delays, sparse ticks, reads during the transfer
    extraTag = " R12";
    csToClk = 8'd0; clkToCs = 8'd0; frameGap = 8'd0; csRest = 8'd0;
    sckLow = 8'd0; sckHigh = 8'd0;
    tickDiv = 3;
    pushByte(8'h01); pushByte(8'h80); pushByte(8'h7E);
    waitCycles(60);
    popByte();
    waitIdle();
    popByte(); popByte();
    tickDiv = 1;
    extraTag = "";

    // disable during a transfer: overflow clears, queued bytes resume later
    pushByte(8'h99); pushByte(8'h66);
    waitCycles(4);
    @(posedge clk); #(CLK_PERIOD/4);
    enable = 1'b0;
    extraTag = " R2";
    waitCycles(5);
    @(negedge clk);
    chk("R2 R10 overflow cleared", 32'(rxOverflow), 32'd0);
    chk("R2 csN released", 32'(csN), 32'd1);
    @(posedge clk); #(CLK_PERIOD/4);
    enable = 1'b1;
    extraTag = "";
    waitIdle();
    for (int i = 0; i < 4; i++) popByte();
    waitCycles(4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule